// File: doc/BRIEF.md
# Cascaded Inverter High/Medium Stage State Selector

Once per sampling period this block chooses the switching state of the two upper stages of a three-stage cascaded inverter. The stages have dc sources in the ratio 9:3:1 of the base step, which gives 18 output levels. The reference vector arrives in 60-degree g-h coordinates as signed fixed point, with 16 codes per base step. An 8-bit magnitude code comes with it; one base step is 0x10 and full scale is 0xEC. The block first picks the two-level high stage state and then the three-level medium stage state. It registers both, together with the residual vector that is left for the low stage modulator.

Each stage keeps its present state while the reference stays inside the hexagonal domain of that state. When the reference leaves the domain, the block tests every candidate state in parallel. From the candidates whose domain holds the reference, it takes the one that changes the fewest phase digits. This keeps the high stage switching near the fundamental frequency and the medium stage switching only a few times per cycle. The sample strobe marks the sample boundary, and both selections and the residual update together on it.

Top module: `stage_state_sel`

## Requirements
- R1: While rst_ni is low, and directly after it falls, hi_state_o is 0, md_state_o is 0, and both residual outputs are 0.
- R2: All outputs change only at the clock edge on which sample_i is high. On every other edge they hold their values, whatever ref_g_i, ref_h_i and mag_i do.
- R3: hi_state_o packs the digits as {xa,xb,xc}, and its vector is (9*(xa-xb), 9*(xb-xc)) steps. md_state_o packs the digits as {ya[5:4],yb[3:2],yc[1:0]}, each digit is 0 to 2, and its vector is (3*(ya-yb), 3*(yb-yc)) steps. The residual outputs equal the sampled reference minus both selected vectors, in 1/16-step units.
- R4: An offset (dg,dh) from a domain centre lies inside a domain of side S when |dg|<=S, |dh|<=S and |dg+dh|<=S. All three bounds are inclusive.
- R5: If the reference lies inside the domain of the present state, that state is kept. This applies to the high stage and to the medium stage.
- R6: If exactly one candidate domain holds the reference, that candidate is selected.
- R7: If several candidate domains hold the reference, the candidate with the fewest changed digits relative to the present state is selected. Ties go to the lowest index. The high index is {xa,xb,xc}; the medium index is ya*9+yb*3+yc.
- R8: If no candidate domain holds the reference, the present state is kept.
- R9: The high-stage domain has side 7 steps when mag_i*5 < 236*4, that is mag_i <= 188. Otherwise it has side 8 steps.
- R10: The medium stage is evaluated after the high stage. Its domains have side 2 steps and are centred on the newly selected high vector plus each medium vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample boundary strobe |
| ref_g_i | input | W (12) | Reference g coordinate, signed, 1/16 step |
| ref_h_i | input | W (12) | Reference h coordinate, signed, 1/16 step |
| mag_i | input | MAG_W (8) | Reference magnitude code, full scale 0xEC |
| hi_state_o | output | 3 | High stage digits {xa,xb,xc} |
| md_state_o | output | 6 | Medium stage ternary digits {ya,yb,yc} |
| res_g_o | output | W (12) | Residual g for the low stage, signed |
| res_h_o | output | W (12) | Residual h for the low stage, signed |

## Verification
The bench walks a chained sequence of references, so each step starts from the state the previous one left. Several steps have more than one feasible candidate. A design that compares against the wrong state, or breaks ties towards the highest index, lands on a neighbouring vector and gives a wrong residual. The side-7 and side-8 switch is tested at codes 188 and 189, and an offset of exactly 8 steps checks that the domain bounds are inclusive. An out-of-range reference must leave both states unchanged rather than jump to an arbitrary state. An idle period with changing inputs catches a design that updates without the strobe.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int HI_N  = 8;
  localparam int MD_N  = 27;
  localparam int HI_IW = 3;
  localparam int MD_IW = 5;

  typedef logic [2:0] hi_code_t;
  typedef logic [5:0] md_code_t;

  function automatic logic [1:0] bit_moves(input hi_code_t a, input hi_code_t b);
    hi_code_t d;
    d = a ^ b;
    return 2'(d[0]) + 2'(d[1]) + 2'(d[2]);
  endfunction

  function automatic logic [1:0] trit_moves(input md_code_t a, input md_code_t b);
    return 2'(a[1:0] != b[1:0]) + 2'(a[3:2] != b[3:2]) + 2'(a[5:4] != b[5:4]);
  endfunction
endpackage

// File: rtl/sss_hex_in.sv
module sss_hex_in #(
  parameter int W = 14
) (
  input  logic signed [W-1:0] dg_i,
  input  logic signed [W-1:0] dh_i,
  input  logic signed [W-1:0] side_i,
  output logic                inside_o
);
  function automatic logic signed [W+1:0] absv(input logic signed [W+1:0] v);
    return (v < 0) ? -v : v;
  endfunction

  logic signed [W+1:0] g_x, h_x, s_x, ag, ah, as_;

  assign g_x = (W+2)'(dg_i);
  assign h_x = (W+2)'(dh_i);
  assign s_x = (W+2)'(side_i);
  assign ag  = absv(g_x);
  assign ah  = absv(h_x);
  assign as_ = absv(g_x + h_x);
  assign inside_o = (ag <= s_x) && (ah <= s_x) && (as_ <= s_x);
endmodule

// File: rtl/sss_pick.sv
module sss_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  feas_i,
  input  logic [1:0]    moves_i [N],
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [2:0] best;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    best  = 3'd4;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (feas_i[i] && ({1'b0, moves_i[i]} < best)) begin
        best  = {1'b0, moves_i[i]};
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/stage_state_sel.sv
module stage_state_sel
  import sss_pkg::*;
#(
  parameter int W        = 12,
  parameter int FRAC     = 4,
  parameter int HI_STEP  = 9,
  parameter int MD_STEP  = 3,
  parameter int MD_SIDE  = 2,
  parameter int SIDE_LO  = 7,
  parameter int SIDE_HI  = 8,
  parameter int MAG_W    = 8,
  parameter int MAG_FULL = 236,
  parameter int THR_NUM  = 4,
  parameter int THR_DEN  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic signed [W-1:0]  ref_g_i,
  input  logic signed [W-1:0]  ref_h_i,
  input  logic [MAG_W-1:0]     mag_i,
  output logic [2:0]           hi_state_o,
  output logic [5:0]           md_state_o,
  output logic signed [W-1:0]  res_g_o,
  output logic signed [W-1:0]  res_h_o
);
  localparam int ONE  = 1 << FRAC;
  localparam int HI_U = HI_STEP * ONE;
  localparam int MD_U = MD_STEP * ONE;
  localparam int WI   = W + 2;

  logic                 wide_side;
  logic signed [WI-1:0] hi_side, md_side, rg, rh;

  assign wide_side = (int'(mag_i) * THR_DEN) >= (MAG_FULL * THR_NUM);
  assign hi_side   = wide_side ? WI'(SIDE_HI * ONE) : WI'(SIDE_LO * ONE);
  assign md_side   = WI'(MD_SIDE * ONE);
  assign rg        = WI'(ref_g_i);
  assign rh        = WI'(ref_h_i);

  hi_code_t             hi_q, hi_nxt, hi_pk;
  logic [MD_IW-1:0]     md_q, md_nxt, md_pk;
  logic signed [W-1:0]  res_g_q, res_h_q;

  // high stage
  logic signed [WI-1:0] hi_cg [HI_N];
  logic signed [WI-1:0] hi_ch [HI_N];
  logic [HI_N-1:0]      hi_feas;
  logic [1:0]           hi_mv [HI_N];
  logic                 hi_any;

  for (genvar i = 0; i < HI_N; i++) begin : g_hi
    localparam int XA = (i >> 2) & 1;
    localparam int XB = (i >> 1) & 1;
    localparam int XC = i & 1;
    assign hi_cg[i] = WI'(HI_U * (XA - XB));
    assign hi_ch[i] = WI'(HI_U * (XB - XC));
    sss_hex_in #(.W(WI)) u_hex (
      .dg_i    (rg - hi_cg[i]),
      .dh_i    (rh - hi_ch[i]),
      .side_i  (hi_side),
      .inside_o(hi_feas[i])
    );
    assign hi_mv[i] = bit_moves(HI_IW'(i), hi_q);
  end

  sss_pick #(.N(HI_N), .IW(HI_IW)) u_hi_pick (
    .feas_i (hi_feas),
    .moves_i(hi_mv),
    .idx_o  (hi_pk),
    .any_o  (hi_any)
  );

  assign hi_nxt = (hi_feas[hi_q] || !hi_any) ? hi_q : hi_pk;

  // medium stage, centred on the new high vector
  logic signed [WI-1:0] mg, mh;
  logic signed [WI-1:0] md_cg [MD_N];
  logic signed [WI-1:0] md_ch [MD_N];
  md_code_t             md_tab [MD_N];
  logic [MD_N-1:0]      md_feas;
  logic [1:0]           md_mv [MD_N];
  logic                 md_any;

  assign mg = rg - hi_cg[hi_nxt];
  assign mh = rh - hi_ch[hi_nxt];

  for (genvar j = 0; j < MD_N; j++) begin : g_md
    localparam int YA = j / 9;
    localparam int YB = (j / 3) % 3;
    localparam int YC = j % 3;
    assign md_tab[j] = {2'(YA), 2'(YB), 2'(YC)};
    assign md_cg[j]  = WI'(MD_U * (YA - YB));
    assign md_ch[j]  = WI'(MD_U * (YB - YC));
    sss_hex_in #(.W(WI)) u_hex (
      .dg_i    (mg - md_cg[j]),
      .dh_i    (mh - md_ch[j]),
      .side_i  (md_side),
      .inside_o(md_feas[j])
    );
    assign md_mv[j] = trit_moves(md_tab[j], md_tab[md_q]);
  end

  sss_pick #(.N(MD_N), .IW(MD_IW)) u_md_pick (
    .feas_i (md_feas),
    .moves_i(md_mv),
    .idx_o  (md_pk),
    .any_o  (md_any)
  );

  assign md_nxt = (md_feas[md_q] || !md_any) ? md_q : md_pk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      md_q    <= '0;
      res_g_q <= '0;
      res_h_q <= '0;
    end else if (sample_i) begin
      hi_q    <= hi_nxt;
      md_q    <= md_nxt;
      res_g_q <= W'(mg - md_cg[md_nxt]);
      res_h_q <= W'(mh - md_ch[md_nxt]);
    end
  end

  assign hi_state_o = hi_q;
  assign md_state_o = md_tab[md_q];
  assign res_g_o    = res_g_q;
  assign res_h_o    = res_h_q;
endmodule

// File: rtl/stage_state_sel_chk.sv
module stage_state_sel_chk #(
  parameter int W       = 12,
  parameter int FRAC    = 4,
  parameter int HI_STEP = 9,
  parameter int MD_STEP = 3,
  parameter int MD_SIDE = 2,
  parameter int SIDE_HI = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_i,
  input logic signed [W-1:0] ref_g_i,
  input logic signed [W-1:0] ref_h_i,
  input logic [2:0]          hi_state_o,
  input logic [5:0]          md_state_o,
  input logic signed [W-1:0] res_g_o,
  input logic signed [W-1:0] res_h_o
);
  localparam int ONE  = 1 << FRAC;
  localparam int HI_U = HI_STEP * ONE;
  localparam int MD_U = MD_STEP * ONE;

  function automatic bit hex_ok(input int g, input int h, input int s);
    int ag, ah, as_;
    ag  = (g < 0) ? -g : g;
    ah  = (h < 0) ? -h : h;
    as_ = (g + h < 0) ? -(g + h) : g + h;
    return (ag <= s) && (ah <= s) && (as_ <= s);
  endfunction

  int md_vg, md_vh;
  assign md_vg = MD_U * (int'(md_state_o[5:4]) - int'(md_state_o[3:2]));
  assign md_vh = MD_U * (int'(md_state_o[3:2]) - int'(md_state_o[1:0]));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> ($stable(hi_state_o) && $stable(md_state_o) && $stable(res_g_o) && $stable(res_h_o)));

  // R3
  trit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (md_state_o[5:4] != 2'd3) && (md_state_o[3:2] != 2'd3) && (md_state_o[1:0] != 2'd3));

  // R3
  resid_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (res_g_o == W'(int'($past(ref_g_i))
                   - HI_U * (int'(hi_state_o[2]) - int'(hi_state_o[1])) - md_vg))
              && (res_h_o == W'(int'($past(ref_h_i))
                   - HI_U * (int'(hi_state_o[1]) - int'(hi_state_o[0])) - md_vh)));

  // R10
  md_move_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_i) && (md_state_o != $past(md_state_o)))
      |-> hex_ok(int'(res_g_o), int'(res_h_o), MD_SIDE * ONE));

  // R6
  hi_move_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sample_i) && (hi_state_o != $past(hi_state_o)))
      |-> hex_ok(int'(res_g_o) + md_vg, int'(res_h_o) + md_vh, SIDE_HI * ONE));
endmodule

bind stage_state_sel stage_state_sel_chk #(
  .W(W), .FRAC(FRAC), .HI_STEP(HI_STEP), .MD_STEP(MD_STEP),
  .MD_SIDE(MD_SIDE), .SIDE_HI(SIDE_HI)
) u_chk (.*);

// File: tb/sim_stage_state_sel.sv
module sim_stage_state_sel;
  localparam int CLK_NS = 10;
  localparam int W      = 12;
  localparam int NV     = 10;

  typedef struct packed {
    logic [W-1:0] g;
    logic [W-1:0] h;
    logic [7:0]   mag;
    logic [2:0]   hi;
    logic [5:0]   md;
    logic [W-1:0] rg;
    logic [W-1:0] rh;
  } vec_t;

  // chained: each row starts from the state left by the row before
  localparam vec_t TBL [NV] = '{
    '{12'd160,            12'd0,            8'd200, 3'd4, 6'h00, 12'd16,              12'd0},
    '{12'd160,            12'd96,           8'd200, 3'd4, 6'h28, 12'd16,              12'd0},
    '{W'(-64),            12'd64,           8'd200, 3'd0, 6'h08, 12'd32,              W'(-32)},
    '{W'(-80),            12'd80,           8'd200, 3'd0, 6'h08, 12'd16,              W'(-16)},
    '{12'd120,            12'd0,            8'd189, 3'd0, 6'h20, 12'd24,              12'd0},
    '{12'd120,            12'd0,            8'd188, 3'd4, 6'h00, W'(-24),             12'd0},
    '{12'd320,            12'd0,            8'd200, 3'd4, 6'h00, 12'd176,             12'd0},
    '{W'(-48),            12'd96,           8'd200, 3'd0, 6'h18, 12'd0,               12'd0},
    '{12'd128,            12'd0,            8'd200, 3'd0, 6'h20, 12'd32,              12'd0},
    '{12'd128,            12'd0,            8'd188, 3'd4, 6'h00, W'(-16),             12'd0}
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R6 R5 single high, medium kept";
      1: return "R5 R6 R10 high kept, single medium";
      2: return "R7 R10 fewest medium digit changes";
      3: return "R5 R3 both kept, residual";
      4: return "R9 R4 code 189 side 8";
      5: return "R9 R7 code 188 side 7";
      6: return "R8 no feasible state";
      7: return "R7 high tie to lowest index";
      8: return "R4 R10 inclusive bound";
      default: return "R9 R3 side 7 at bound";
    endcase
  endfunction

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                sample_i = 1'b0;
  logic signed [W-1:0] ref_g_i = '0;
  logic signed [W-1:0] ref_h_i = '0;
  logic [7:0]          mag_i = '0;
  logic [2:0]          hi_state_o;
  logic [5:0]          md_state_o;
  logic signed [W-1:0] res_g_o, res_h_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  stage_state_sel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i),
    .ref_g_i(ref_g_i), .ref_h_i(ref_h_i), .mag_i(mag_i),
    .hi_state_o(hi_state_o), .md_state_o(md_state_o),
    .res_g_o(res_g_o), .res_h_o(res_h_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int hi, input int md, input int rg, input int rh);
    chk(req, "hi_state", int'(hi_state_o), hi);
    chk(req, "md_state", int'(md_state_o), md);
    chk(req, "res_g", int'(res_g_o), rg);
    chk(req, "res_h", int'(res_h_o), rh);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 0, 0, 0, 0);
    rst_ni = 1'b1;

    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      ref_g_i  = $signed(TBL[r].g);
      ref_h_i  = $signed(TBL[r].h);
      mag_i    = TBL[r].mag;
      sample_i = 1'b1;
      @(negedge clk);
      sample_i = 1'b0;
      chk_all(row_tag(r), int'(TBL[r].hi), int'(TBL[r].md),
              int'($signed(TBL[r].rg)), int'($signed(TBL[r].rh)));
    end

    // R2: inputs move, no strobe
    @(negedge clk);
    ref_g_i = -12'sd200;
    ref_h_i = 12'sd90;
    mag_i   = 8'd10;
    repeat (4) @(negedge clk);
    chk_all("R2 idle inputs ignored", 4, 0, -16, 0);

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk_all("R1 async reset", 0, 0, 0, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 0, 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule